// File: doc/BRIEF.md
# Latency Tolerance Reporting Controller

This block tracks how much service latency a host controller can currently absorb and reports that figure to a power management unit. It keeps one of four tolerance levels: High, Medium, Low and Active. Each level carries a tolerance in nanoseconds. High, Medium and Low take fixed values set by parameters. Active takes its value from a programmable periodic-active field, which is a 10-bit count multiplied by a power of two chosen by a 2-bit scale.

An alarm timer expiry moves the machine toward Active, and a service boundary brings it back to High. A mode input picks one of two ways to move on an alarm. In direct mode the machine jumps straight to Active. In stepped mode it moves one level per alarm, and only when the remaining latency budget covers the tolerance of the level it would enter. Each change of level produces a one-cycle message strobe. The strobe carries the tolerance of the new level, so the power manager sees one update per change.

Top module: `ltr_fsm`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the level is High (encoding 0), msg_valid is 0 and msg_ns is 0. Level encodings are High=0, Medium=1, Low=2, Active=3.
- R2: When ltr_en is 0 at a clock edge, the level after that edge is High and msg_valid is 0, whatever alarm_exp or svc_bound do.
- R3: With ltr_en=1 and step_mode=0, an alarm_exp in High, Medium or Low moves the level to Active at the next edge.
- R4: In Active, the level stays Active until a service boundary arrives, and alarm_exp has no effect there.
- R5: With ltr_en=1, svc_bound moves the level to High at the next edge. It takes priority over alarm_exp.
- R6: With ltr_en=1 and step_mode=1, each alarm_exp advances the level by exactly one step (High to Medium to Low to Active). The step is taken only when budget_ns is at least the tolerance of the target level. Otherwise the level stays where it is.
- R7: msg_valid pulses for one cycle, registered with the new level, on every level change made while ltr_en=1. msg_ns then holds the new level's tolerance. No pulse occurs while the level is unchanged.
- R8: The tolerances are HIGH_NS, MED_NS and LOW_NS (defaults 1,000,000, 100,000 and 10,000) for High, Medium and Low. Active uses pa_value times 1024, 32,768 or 1,048,576 for pa_scale 1, 2 or 3.
- R9: pa_scale 0 is reserved. It gives an Active tolerance of 0 and drives scale_err high combinationally. scale_err is low for any other scale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ltr_en | input | 1 | Enables level tracking and messages |
| step_mode | input | 1 | 0: direct jump to Active; 1: budget-gated stepping |
| alarm_exp | input | 1 | Alarm timer expiry strobe |
| svc_bound | input | 1 | Service boundary strobe |
| budget_ns | input | NS_W | Remaining latency budget in ns |
| pa_scale | input | 2 | Periodic-active scale select |
| pa_value | input | VAL_W | Periodic-active count |
| lt_state | output | 2 | Current level |
| msg_valid | output | 1 | One-cycle message strobe |
| msg_ns | output | NS_W | Tolerance carried by the message |
| scale_err | output | 1 | Reserved scale in use |

## Verification
The checker assumes that svc_bound and alarm_exp are sampled only at rising edges, and that pa_scale and pa_value are stable across the edge on which the level enters Active, because the message value is taken from them at that edge. The checker also assumes that budget_ns is read only when a stepped alarm is present. The bench changes every input half a cycle away from the sampling edge and holds it for a full cycle, so each of these conditions is met. It also combines strobes deliberately, for example an alarm together with a service boundary, or an alarm while the block is disabled, so that the rules on priority and on ignoring a strobe are exercised.

// File: rtl/ltr_pkg.sv
package ltr_pkg;
   typedef enum logic [1:0] {
      LTR_HIGH = 2'd0,
      LTR_MED  = 2'd1,
      LTR_LOW  = 2'd2,
      LTR_ACT  = 2'd3
   } ltr_level_e;
endpackage

// File: rtl/ltr_lat_decode.sv
module ltr_lat_decode #(
   parameter int VAL_W = 10,
   parameter int NS_W  = 32,
   parameter int SH1   = 10,
   parameter int SH2   = 15,
   parameter int SH3   = 20
) (
   input  logic [1:0]       scale,
   input  logic [VAL_W-1:0] value,
   output logic [NS_W-1:0]  act_ns,
   output logic             bad_scale
);
   localparam int PAD_W = NS_W - VAL_W;

   logic [NS_W-1:0] wide_val;
   assign wide_val = {{PAD_W{1'b0}}, value};

   always_comb begin
      bad_scale = 1'b0;
      unique case (scale)
         2'd1:    act_ns = wide_val << SH1;
         2'd2:    act_ns = wide_val << SH2;
         2'd3:    act_ns = wide_val << SH3;
         default: begin
            act_ns    = '0;
            bad_scale = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/ltr_next_level.sv
module ltr_next_level
   import ltr_pkg::*;
#(
   parameter int              NS_W    = 32,
   parameter logic [NS_W-1:0] HIGH_NS = 1_000_000,
   parameter logic [NS_W-1:0] MED_NS  = 100_000,
   parameter logic [NS_W-1:0] LOW_NS  = 10_000
) (
   input  ltr_level_e       cur,
   input  logic             en,
   input  logic             stepped,
   input  logic             alarm,
   input  logic             svc,
   input  logic [NS_W-1:0]  budget,
   input  logic [NS_W-1:0]  act_ns,
   output ltr_level_e       nxt,
   output logic [NS_W-1:0]  nxt_ns,
   output logic             announce
);
   ltr_level_e      step_tgt;
   logic [NS_W-1:0] step_need;

   always_comb begin
      unique case (cur)
         LTR_HIGH: step_tgt = LTR_MED;
         LTR_MED:  step_tgt = LTR_LOW;
         default:  step_tgt = LTR_ACT;
      endcase
      unique case (step_tgt)
         LTR_MED: step_need = MED_NS;
         LTR_LOW: step_need = LOW_NS;
         default: step_need = act_ns;
      endcase
   end

   always_comb begin
      nxt = cur;
      if (!en)
         nxt = LTR_HIGH;
      else if (svc)
         nxt = LTR_HIGH;
      else if (alarm && cur != LTR_ACT) begin
         if (!stepped)
            nxt = LTR_ACT;
         else if (budget >= step_need)
            nxt = step_tgt;
      end
   end

   always_comb begin
      unique case (nxt)
         LTR_HIGH: nxt_ns = HIGH_NS;
         LTR_MED:  nxt_ns = MED_NS;
         LTR_LOW:  nxt_ns = LOW_NS;
         default:  nxt_ns = act_ns;
      endcase
   end

   assign announce = en && (nxt != cur);
endmodule

// File: rtl/ltr_msg_reg.sv
module ltr_msg_reg
   import ltr_pkg::*;
#(
   parameter int NS_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  ltr_level_e      nxt,
   input  logic            announce,
   input  logic [NS_W-1:0] nxt_ns,
   output ltr_level_e      level_q,
   output logic            valid_q,
   output logic [NS_W-1:0] ns_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= LTR_HIGH;
         valid_q <= 1'b0;
         ns_q    <= '0;
      end else begin
         level_q <= nxt;
         valid_q <= announce;
         if (announce)
            ns_q <= nxt_ns;
      end
   end
endmodule

// File: rtl/ltr_fsm.sv
module ltr_fsm
   import ltr_pkg::*;
#(
   parameter int              VAL_W   = 10,
   parameter int              NS_W    = 32,
   parameter int              SH1     = 10,
   parameter int              SH2     = 15,
   parameter int              SH3     = 20,
   parameter logic [NS_W-1:0] HIGH_NS = 1_000_000,
   parameter logic [NS_W-1:0] MED_NS  = 100_000,
   parameter logic [NS_W-1:0] LOW_NS  = 10_000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ltr_en,
   input  logic             step_mode,
   input  logic             alarm_exp,
   input  logic             svc_bound,
   input  logic [NS_W-1:0]  budget_ns,
   input  logic [1:0]       pa_scale,
   input  logic [VAL_W-1:0] pa_value,
   output logic [1:0]       lt_state,
   output logic             msg_valid,
   output logic [NS_W-1:0]  msg_ns,
   output logic             scale_err
);
   localparam int MAX_SH = (SH3 > SH2) ? ((SH3 > SH1) ? SH3 : SH1)
                                       : ((SH2 > SH1) ? SH2 : SH1);

   generate
      if (NS_W < VAL_W + MAX_SH) begin : g_bad_width
         $error("ltr_fsm: NS_W too narrow for the largest scaled value");
      end
      if (!(HIGH_NS > MED_NS && MED_NS > LOW_NS)) begin : g_bad_order
         $error("ltr_fsm: tolerances must fall from High to Low");
      end
      if (VAL_W < 1) begin : g_bad_val
         $error("ltr_fsm: VAL_W must be positive");
      end
   endgenerate

   logic [NS_W-1:0] act_ns;
   logic [NS_W-1:0] nxt_ns;
   ltr_level_e      cur_lvl;
   ltr_level_e      nxt_lvl;
   logic            announce;

   ltr_lat_decode #(
      .VAL_W(VAL_W), .NS_W(NS_W), .SH1(SH1), .SH2(SH2), .SH3(SH3)
   ) u_decode (
      .scale     (pa_scale),
      .value     (pa_value),
      .act_ns    (act_ns),
      .bad_scale (scale_err)
   );

   ltr_next_level #(
      .NS_W(NS_W), .HIGH_NS(HIGH_NS), .MED_NS(MED_NS), .LOW_NS(LOW_NS)
   ) u_next (
      .cur      (cur_lvl),
      .en       (ltr_en),
      .stepped  (step_mode),
      .alarm    (alarm_exp),
      .svc      (svc_bound),
      .budget   (budget_ns),
      .act_ns   (act_ns),
      .nxt      (nxt_lvl),
      .nxt_ns   (nxt_ns),
      .announce (announce)
   );

   ltr_msg_reg #(.NS_W(NS_W)) u_msg (
      .clk      (clk),
      .rst_n    (rst_n),
      .nxt      (nxt_lvl),
      .announce (announce),
      .nxt_ns   (nxt_ns),
      .level_q  (cur_lvl),
      .valid_q  (msg_valid),
      .ns_q     (msg_ns)
   );

   assign lt_state = cur_lvl;
endmodule

// File: rtl/ltr_fsm_chk.sv
module ltr_fsm_chk #(
   parameter int NS_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            ltr_en,
   input logic            step_mode,
   input logic            alarm_exp,
   input logic            svc_bound,
   input logic [1:0]      pa_scale,
   input logic [1:0]      lt_state,
   input logic            msg_valid,
   input logic [NS_W-1:0] msg_ns,
   input logic            scale_err
);
   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !ltr_en |=> (lt_state == 2'd0 && !msg_valid)); // R2

   AST_DIRECT_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
      (ltr_en && !step_mode && alarm_exp && !svc_bound) |=> lt_state == 2'd3); // R3

   AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ltr_en && !svc_bound && lt_state == 2'd3) |=> lt_state == 2'd3); // R4

   AST_SVC_TO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (ltr_en && svc_bound) |=> lt_state == 2'd0); // R5

   AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ltr_en && step_mode && !svc_bound && lt_state != 2'd3)
      |=> (lt_state == $past(lt_state) || lt_state == $past(lt_state) + 2'd1)); // R6

   AST_MSG_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> lt_state != $past(lt_state)); // R7

   AST_NO_MSG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (ltr_en && lt_state == 2'd0 && !alarm_exp) |=> !msg_valid); // R7

   AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (ltr_en && !svc_bound && alarm_exp && !step_mode && pa_scale == 2'd0
       && lt_state != 2'd3) |=> msg_ns == '0); // R9

   always_comb begin
      AST_SCALE_FLAG: assert (scale_err == (pa_scale == 2'd0)); // R9
   end
endmodule

bind ltr_fsm ltr_fsm_chk #(.NS_W(NS_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ltr_en    (ltr_en),
   .step_mode (step_mode),
   .alarm_exp (alarm_exp),
   .svc_bound (svc_bound),
   .pa_scale  (pa_scale),
   .lt_state  (lt_state),
   .msg_valid (msg_valid),
   .msg_ns    (msg_ns),
   .scale_err (scale_err)
);

// File: tb/ltr_fsm_bench.sv
`timescale 1ns/1ps
module ltr_fsm_bench;
   localparam int NS_W  = 32;
   localparam int VAL_W = 10;

   typedef struct packed {
      logic        en;
      logic        pol;
      logic        al;
      logic        svc;
      logic [31:0] bud;
      logic [1:0]  scl;
      logic [9:0]  val;
      logic [1:0]  st;
      logic        vld;
      logic [31:0] ns;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 23;
   localparam vec_t VEC [0:NV-1] = '{
      '{1'b1,1'b0,1'b0,1'b0,32'd0,     2'd1,10'd3,   2'd0,1'b0,32'd0,          4'd7}, // R7 idle
      '{1'b1,1'b0,1'b1,1'b0,32'd0,     2'd1,10'd3,   2'd3,1'b1,32'd3072,       4'd3}, // R3 R8
      '{1'b1,1'b0,1'b1,1'b0,32'd0,     2'd1,10'd3,   2'd3,1'b0,32'd0,          4'd4}, // R4
      '{1'b1,1'b1,1'b1,1'b0,32'hFFFFFF,2'd1,10'd3,   2'd3,1'b0,32'd0,          4'd4}, // R4
      '{1'b1,1'b0,1'b0,1'b1,32'd0,     2'd1,10'd3,   2'd0,1'b1,32'd1000000,    4'd5}, // R5
      '{1'b1,1'b1,1'b1,1'b0,32'd50000, 2'd1,10'd3,   2'd0,1'b0,32'd0,          4'd6}, // R6 short budget
      '{1'b1,1'b1,1'b1,1'b0,32'd100000,2'd1,10'd3,   2'd1,1'b1,32'd100000,     4'd6}, // R6 exact budget
      '{1'b1,1'b1,1'b0,1'b0,32'd100000,2'd1,10'd3,   2'd1,1'b0,32'd0,          4'd7}, // R7 stable
      '{1'b1,1'b1,1'b1,1'b0,32'd10000, 2'd1,10'd3,   2'd2,1'b1,32'd10000,      4'd6}, // R6
      '{1'b1,1'b1,1'b1,1'b0,32'd5000,  2'd2,10'd1,   2'd2,1'b0,32'd0,          4'd6}, // R6 blocked
      '{1'b1,1'b1,1'b1,1'b0,32'd40000, 2'd2,10'd1,   2'd3,1'b1,32'd32768,      4'd8}, // R8 R6
      '{1'b1,1'b0,1'b1,1'b1,32'd0,     2'd2,10'd1,   2'd0,1'b1,32'd1000000,    4'd5}, // R5 priority
      '{1'b1,1'b0,1'b1,1'b0,32'd0,     2'd3,10'd2,   2'd3,1'b1,32'd2097152,    4'd8}, // R8
      '{1'b1,1'b0,1'b0,1'b1,32'd0,     2'd3,10'd2,   2'd0,1'b1,32'd1000000,    4'd5}, // R5
      '{1'b1,1'b0,1'b1,1'b0,32'd0,     2'd0,10'd5,   2'd3,1'b1,32'd0,          4'd9}, // R9
      '{1'b0,1'b0,1'b1,1'b0,32'd0,     2'd1,10'd5,   2'd0,1'b0,32'd0,          4'd2}, // R2
      '{1'b0,1'b0,1'b1,1'b0,32'd0,     2'd1,10'd5,   2'd0,1'b0,32'd0,          4'd2}, // R2
      '{1'b1,1'b1,1'b1,1'b0,32'd200000,2'd1,10'd0,   2'd1,1'b1,32'd100000,     4'd6}, // R6
      '{1'b0,1'b1,1'b0,1'b1,32'd0,     2'd1,10'd0,   2'd0,1'b0,32'd0,          4'd2}, // R2 silent drop
      '{1'b1,1'b0,1'b1,1'b0,32'd0,     2'd1,10'd0,   2'd3,1'b1,32'd0,          4'd8}, // R8 zero count
      '{1'b1,1'b0,1'b0,1'b0,32'd0,     2'd1,10'd0,   2'd3,1'b0,32'd0,          4'd4}, // R4
      '{1'b1,1'b0,1'b0,1'b1,32'd0,     2'd3,10'd1023,2'd0,1'b1,32'd1000000,    4'd5}, // R5
      '{1'b1,1'b0,1'b1,1'b0,32'd0,     2'd3,10'd1023,2'd3,1'b1,32'd1072693248, 4'd8}  // R8 max
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ltr_en = 1'b0, step_mode = 1'b0, alarm_exp = 1'b0, svc_bound = 1'b0;
   logic [NS_W-1:0]  budget_ns = '0;
   logic [1:0]       pa_scale = 2'd1;
   logic [VAL_W-1:0] pa_value = '0;
   logic [1:0]       lt_state;
   logic             msg_valid;
   logic [NS_W-1:0]  msg_ns;
   logic             scale_err;

   int  n_chk = 0;
   int  n_err = 0;
   bit  done  = 1'b0;

   always #2.5 clk = ~clk;

   ltr_fsm u_ltr_fsm (
      .clk(clk), .rst_n(rst_n), .ltr_en(ltr_en), .step_mode(step_mode),
      .alarm_exp(alarm_exp), .svc_bound(svc_bound), .budget_ns(budget_ns),
      .pa_scale(pa_scale), .pa_value(pa_value), .lt_state(lt_state),
      .msg_valid(msg_valid), .msg_ns(msg_ns), .scale_err(scale_err)
   );

   task automatic chk(string tag, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step_edge();
      @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual 1 expected 0");
      finish_run();
   end

   initial begin
      // R1: reset state
      #7;
      chk("R1 state", lt_state, 0);
      chk("R1 valid", msg_valid, 0);
      chk("R1 ns", msg_ns, 0);
      @(negedge clk);
      rst_n = 1'b1;
      step_edge();
      chk("R1 state after release", lt_state, 0);
      chk("R1 valid after release", msg_valid, 0);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         ltr_en    = VEC[i].en;
         step_mode = VEC[i].pol;
         alarm_exp = VEC[i].al;
         svc_bound = VEC[i].svc;
         budget_ns = VEC[i].bud;
         pa_scale  = VEC[i].scl;
         pa_value  = VEC[i].val;
         step_edge();
         chk($sformatf("R%0d vec%0d state", VEC[i].req, i), lt_state, VEC[i].st);
         chk($sformatf("R%0d vec%0d valid", VEC[i].req, i), msg_valid, VEC[i].vld);
         if (VEC[i].vld)
            chk($sformatf("R%0d vec%0d ns", VEC[i].req, i), msg_ns, VEC[i].ns);
      end

      // R9: reserved-scale flag is combinational
      @(negedge clk);
      alarm_exp = 1'b0;
      svc_bound = 1'b0;
      pa_scale  = 2'd0;
      #1;
      chk("R9 flag on scale 0", scale_err, 1);
      pa_scale = 2'd2;
      #1;
      chk("R9 flag off scale 2", scale_err, 0);

      // R6: stepped alarm in Active does nothing, stays Active (R4)
      @(negedge clk);
      step_mode = 1'b1;
      alarm_exp = 1'b1;
      budget_ns = '1;
      step_edge();
      chk("R4 stepped alarm in Active", lt_state, 3);
      chk("R7 no message when held", msg_valid, 0);

      // R7: strobe lasts one cycle
      @(negedge clk);
      alarm_exp = 1'b0;
      svc_bound = 1'b1;
      step_edge();
      chk("R7 pulse on change", msg_valid, 1);
      @(negedge clk);
      svc_bound = 1'b0;
      step_edge();
      chk("R7 pulse ends", msg_valid, 0);

      // R1: reset in the middle of a run clears everything
      @(negedge clk);
      step_mode = 1'b0;
      alarm_exp = 1'b1;
      pa_scale  = 2'd1;
      pa_value  = 10'd7;
      step_edge();
      chk("R3 jump before reset", lt_state, 3);
      @(negedge clk);
      alarm_exp = 1'b0;
      rst_n = 1'b0;
      #1;
      chk("R1 mid reset state", lt_state, 0);
      chk("R1 mid reset valid", msg_valid, 0);
      chk("R1 mid reset ns", msg_ns, 0);
      @(negedge clk);
      rst_n = 1'b1;
      step_edge();
      chk("R1 after mid reset", lt_state, 0);

      finish_run();
   end
endmodule